// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and decides which of six interrupt sources gets serviced next. Each source raises a one-cycle request pulse that is held in a sticky pending flag. At the instruction boundary the core signals with a phase strobe, the controller looks at every flag that is pending and enabled. If the master enable is on and the return stack has room, it picks the highest-priority source. It then issues a subroutine-call request carrying that source's fixed vector address.

Accepting a source clears its pending flag and clears the master enable, and the controller enters a service state. It stays there until the core executes a return-from-interrupt, or until software turns the master enable back on, which permits nesting. A plain subroutine return inside the handler changes nothing. The program counter, the stack memory and the instruction decoder belong to the core; the controller only sees the stack-full flag and the two kinds of return.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A source can be accepted only when all four of these hold: its pending flag is set, its bit in `src_en` is set, `mstr_en` is 1, and `stack_full` is 0. With `mstr_en` at 0, no source is accepted whatever its flag and enable.
- R2: Acceptance happens only in a cycle where `phase_stb` is 1. Requests pulsed in the cycles between two strobes stay pending and are all considered at the later strobe.
- R3: Among eligible sources the lowest index wins: bit 0 external, bit 1 timer 0, bit 2 timer 1, bit 3 USB, bit 4 ADC, bit 5 serial.
- R4: `call_vec` is 4*(index+1): 04H external, 08H timer 0, 0CH timer 1, 10H USB, 14H ADC and 18H serial. It is 0 in any cycle without a call.
- R5: In the accepting cycle, `call_req` is 1 and `flag_clr` is one-hot on the winner, both combinationally from that cycle's inputs. At the next edge the winner's pending flag and `mstr_en` both read 0.
- R6: After an acceptance, `in_service` is 1 and no further call is made until a cycle with `reti` or `mstr_set` returns the controller to idle.
- R7: `reti` sets `mstr_en` and ends the service state. `ret` has no effect on `mstr_en`, `in_service` or the flags.
- R8: A pending flag is set by a pulse on `src_pulse` and cleared by acceptance or by `sw_flag_clr`. When a pulse and a clear of the same bit coincide, the flag ends set.
- R9: After reset all pending flags are 0, `mstr_en` is 0, `in_service` is 0 and `call_req` is 0.
- R10: Software control of the master enable has this priority: acceptance clears it first, then `reti` sets it, then `mstr_set` sets it, then `mstr_clr` clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 6 | One-cycle request pulses, bit 0 highest priority |
| src_en | input | 6 | Per-source enable bits |
| sw_flag_clr | input | 6 | Software write clearing pending flags |
| mstr_set | input | 1 | Software write setting the master enable |
| mstr_clr | input | 1 | Software write clearing the master enable |
| stack_full | input | 1 | Return stack has no free entry |
| phase_stb | input | 1 | Instruction-boundary strobe |
| reti | input | 1 | Core executes return-from-interrupt |
| ret | input | 1 | Core executes plain subroutine return |
| call_req | output | 1 | Subroutine-call request to the core |
| call_vec | output | 8 | Vector address of the accepted source |
| flag_clr | output | 6 | One-hot acknowledge of the accepted source |
| pend | output | 6 | Pending flag state |
| mstr_en | output | 1 | Master enable state |
| in_service | output | 1 | Controller is in the service state |

## Verification
The outputs `call_req`, `call_vec` and `flag_clr` are due in the same cycle as the strobe that qualifies them. The effects on `pend`, `mstr_en` and `in_service` are due one clock edge later. The bench applies its inputs on the falling edge and samples every output shortly afterwards. A reference model, advanced only on the following rising edge, supplies each expected value, so combinational results are compared against the pre-edge state and registered results against the state after the previous edge. Directed cases read the captured values one tick after the stimulus that should have changed them.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int unsigned VIC_NSRC = 6;
    localparam int unsigned VIC_VW   = 8;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } vic_state_e;
endpackage

// File: rtl/vic_flags.sv
module vic_flags #(
    parameter int unsigned NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_pulse,
    input  logic [NSRC-1:0] ack_clr,
    input  logic [NSRC-1:0] sw_clr,
    output logic [NSRC-1:0] flag_q
);
    // One sticky latch per source; a new pulse dominates any clear.
    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[g] <= 1'b0;
            end else if (set_pulse[g]) begin
                flag_q[g] <= 1'b1;
            end else if (ack_clr[g] || sw_clr[g]) begin
                flag_q[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int unsigned NSRC = 6,
    localparam int unsigned IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] req,
    output logic [NSRC-1:0] grant,
    output logic [IW-1:0]   idx,
    output logic            valid
);
    // Scan from the lowest priority upward so the lowest index is kept last.
    always_comb begin
        grant = '0;
        idx   = '0;
        valid = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = i[IW-1:0];
                valid    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vic_fsm.sv
module vic_fsm
    import vic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic phase_stb,
    input  logic any_elig,
    input  logic reti,
    input  logic ret,
    input  logic mstr_set,
    input  logic mstr_clr,
    output logic accept,
    output logic mstr_q,
    output logic in_service
);
    vic_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: IDLE -take-> SERVE, SERVE -resume-> IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_SERVE;
                end
            end
            ST_SERVE: begin
                if (reti || mstr_set) begin
                    state_d = ST_IDLE;
                end else if (ret) begin
                    state_d = ST_SERVE;  // plain return keeps the hold-off
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        accept     = 1'b0;
        in_service = 1'b0;
        unique case (state_q)
            ST_IDLE:  accept     = phase_stb && any_elig;
            ST_SERVE: in_service = 1'b1;
            default: begin
                accept     = 1'b0;
                in_service = 1'b0;
            end
        endcase
    end

    // Master enable: acceptance > reti > software set > software clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mstr_q <= 1'b0;
        end else if (accept) begin
            mstr_q <= 1'b0;
        end else if (reti || mstr_set) begin
            mstr_q <= 1'b1;
        end else if (mstr_clr) begin
            mstr_q <= 1'b0;
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
    parameter int unsigned NSRC     = vic_pkg::VIC_NSRC,
    parameter int unsigned VW       = vic_pkg::VIC_VW,
    parameter int unsigned VEC_BASE = 4,
    parameter int unsigned VEC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_pulse,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] sw_flag_clr,
    input  logic            mstr_set,
    input  logic            mstr_clr,
    input  logic            stack_full,
    input  logic            phase_stb,
    input  logic            reti,
    input  logic            ret,
    output logic            call_req,
    output logic [VW-1:0]   call_vec,
    output logic [NSRC-1:0] flag_clr,
    output logic [NSRC-1:0] pend,
    output logic            mstr_en,
    output logic            in_service
);
    localparam int unsigned IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] win_oh;
    logic [IW-1:0]   win_idx;
    logic            win_valid;
    logic            accept;
    logic [VW-1:0]   vec_c;

    vic_flags #(.NSRC(NSRC)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (src_pulse),
        .ack_clr   (flag_clr),
        .sw_clr    (sw_flag_clr),
        .flag_q    (pend)
    );

    // A source qualifies on its flag, its own enable, the master enable and stack room.
    assign elig = pend & src_en & {NSRC{mstr_en & ~stack_full}};

    vic_prio #(.NSRC(NSRC)) u_prio (
        .req   (elig),
        .grant (win_oh),
        .idx   (win_idx),
        .valid (win_valid)
    );

    vic_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_stb  (phase_stb),
        .any_elig   (win_valid),
        .reti       (reti),
        .ret        (ret),
        .mstr_set   (mstr_set),
        .mstr_clr   (mstr_clr),
        .accept     (accept),
        .mstr_q     (mstr_en),
        .in_service (in_service)
    );

    always_comb begin
        vec_c = VW'(VEC_BASE) + VW'(VEC_STEP) * (VW'(win_idx));
    end

    assign call_req = accept;
    assign call_vec = accept ? vec_c : '0;
    assign flag_clr = accept ? win_oh : '0;
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
    parameter int unsigned NSRC = 6,
    parameter int unsigned VW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_pulse,
    input logic [NSRC-1:0] src_en,
    input logic            mstr_set,
    input logic            stack_full,
    input logic            phase_stb,
    input logic            reti,
    input logic            ret,
    input logic            call_req,
    input logic [VW-1:0]   call_vec,
    input logic [NSRC-1:0] flag_clr,
    input logic [NSRC-1:0] pend,
    input logic            mstr_en,
    input logic            in_service
);
    AST_CALL_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (mstr_en && !stack_full && ((flag_clr & pend & src_en) == flag_clr))); // R1
    AST_CALL_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> phase_stb); // R2
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> ((pend & src_en & (flag_clr - 1'b1)) == '0)); // R3
    AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !call_req |-> (call_vec == '0)); // R4
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> ($onehot0(flag_clr) && flag_clr != '0)); // R5
    AST_MASTER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |=> (!mstr_en && in_service)); // R5
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        in_service |-> !call_req); // R6
    AST_RETI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !call_req) |=> (mstr_en && !in_service)); // R7
    AST_RET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && ret && !reti && !mstr_set) |=> in_service); // R7
    AST_PULSE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pulse != '0) |=> ((pend & $past(src_pulse)) == $past(src_pulse))); // R8
endmodule

bind vec_irq_ctrl vic_chk #(.NSRC(NSRC), .VW(VW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_pulse  (src_pulse),
    .src_en     (src_en),
    .mstr_set   (mstr_set),
    .stack_full (stack_full),
    .phase_stb  (phase_stb),
    .reti       (reti),
    .ret        (ret),
    .call_req   (call_req),
    .call_vec   (call_vec),
    .flag_clr   (flag_clr),
    .pend       (pend),
    .mstr_en    (mstr_en),
    .in_service (in_service)
);

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] src_pulse = '0, src_en = '0, sw_flag_clr = '0;
    logic       mstr_set = 0, mstr_clr = 0, stack_full = 0, phase_stb = 0, reti = 0, ret = 0;
    logic       call_req, mstr_en, in_service;
    logic [7:0] call_vec;
    logic [5:0] flag_clr, pend;

    // staged stimulus, applied at the next falling edge
    logic [5:0] s_pulse = '0, s_en = '0, s_swc = '0;
    logic       s_set = 0, s_clr = 0, s_sf = 0, s_stb = 0, s_reti = 0, s_ret = 0;

    // reference model state
    logic [5:0] m_flag = '0;
    logic       m_mstr = 0, m_busy = 0;

    // captured outputs of the last tick
    logic       a_call, a_mstr, a_busy;
    logic [7:0] a_vec;
    logic [5:0] a_clr, a_pend;

    int nchk = 0, nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .src_en(src_en),
        .sw_flag_clr(sw_flag_clr), .mstr_set(mstr_set), .mstr_clr(mstr_clr),
        .stack_full(stack_full), .phase_stb(phase_stb), .reti(reti), .ret(ret),
        .call_req(call_req), .call_vec(call_vec), .flag_clr(flag_clr),
        .pend(pend), .mstr_en(mstr_en), .in_service(in_service)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic int lowest(input logic [5:0] v);
        for (int i = 5; i >= 0; i--) if (v[i]) lowest = i;
        if (v == '0) lowest = -1;
    endfunction

    task automatic tick();
        logic [5:0] elig, woh;
        logic       acc;
        logic [7:0] evec;
        int         w;
        @(negedge clk);
        src_pulse = s_pulse; src_en = s_en; sw_flag_clr = s_swc; mstr_set = s_set;
        mstr_clr = s_clr; stack_full = s_sf; phase_stb = s_stb; reti = s_reti; ret = s_ret;
        s_pulse = '0; s_swc = '0; s_set = 0; s_clr = 0; s_stb = 0; s_reti = 0; s_ret = 0;
        #1;
        elig = m_flag & src_en & {6{m_mstr & ~stack_full}};
        w    = lowest(elig);
        acc  = !m_busy && phase_stb && (elig != '0);
        woh  = acc ? (6'b1 << w) : '0;
        evec = acc ? 8'(4 * (w + 1)) : 8'h00;
        a_call = call_req; a_vec = call_vec; a_clr = flag_clr;
        a_pend = pend; a_mstr = mstr_en; a_busy = in_service;
        chk("R1 call_req", call_req, acc);
        chk("R4 call_vec", call_vec, evec);
        chk("R3 flag_clr", flag_clr, woh);
        chk("R8 pend", pend, m_flag);
        chk("R10 mstr_en", mstr_en, m_mstr);
        chk("R6 in_service", in_service, m_busy);
        @(posedge clk);
        m_flag = src_pulse | (m_flag & ~woh & ~sw_flag_clr);
        if (acc) m_mstr = 0;
        else if (reti || mstr_set) m_mstr = 1;
        else if (mstr_clr) m_mstr = 0;
        if (acc) m_busy = 1;
        else if (m_busy && (reti || mstr_set)) m_busy = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        chk("R9 pend", pend, 0);
        chk("R9 mstr_en", mstr_en, 0);
        chk("R9 call_req", call_req, 0);
        chk("R9 in_service", in_service, 0);

        // R1: master off masks everything
        s_en = 6'h3F; s_pulse = 6'h3F; tick();
        s_stb = 1; tick();
        chk("R1 masked by master", a_call, 0);
        s_swc = 6'h3F; tick();

        // R10: set and clear together leaves the enable set
        s_set = 1; s_clr = 1; tick(); tick();
        chk("R10 set beats clear", a_mstr, 1);

        // R2: pulses between strobes wait, then the lowest index wins
        s_pulse = 6'b000100; tick();
        tick(); tick();
        s_pulse = 6'b000001; tick();
        chk("R2 no strobe no call", a_call, 0);
        s_stb = 1; tick();
        chk("R2 call at strobe", a_call, 1);
        chk("R3 external wins", a_clr, 6'b000001);
        chk("R4 external vector", a_vec, 8'h04);
        s_ret = 1; tick();
        chk("R5 flag cleared", a_pend, 6'b000100);
        chk("R5 master cleared", a_mstr, 0);
        chk("R6 in service", a_busy, 1);
        s_stb = 1; tick();
        chk("R7 ret keeps service", a_busy, 1);
        chk("R7 ret keeps master", a_mstr, 0);
        s_reti = 1; tick();
        s_stb = 1; tick();
        chk("R7 reti sets master", a_mstr, 1);
        chk("R4 timer1 vector", a_vec, 8'h0C);
        s_reti = 1; tick();

        // R1: stack full blocks, serial vector is 18H
        s_sf = 1; s_pulse = 6'b100000; tick();
        s_stb = 1; tick();
        chk("R1 stack full blocks", a_call, 0);
        s_sf = 0; s_stb = 1; tick();
        chk("R4 serial vector", a_vec, 8'h18);
        s_reti = 1; tick();

        // R8: pulse and software clear on the same bit
        s_pulse = 6'b010000; s_swc = 6'b010000; tick();
        tick();
        chk("R8 pulse dominates clear", a_pend & 6'b010000, 6'b010000);
        s_swc = 6'b010000; tick(); tick();
        chk("R8 software clear", a_pend, 0);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            for (int b = 0; b < 6; b++) begin
                if ($urandom_range(7) == 0) s_pulse[b] = 1'b1;
                if ($urandom_range(15) == 0) s_swc[b] = 1'b1;
            end
            if ($urandom_range(15) == 0) s_en = 6'($urandom);
            s_sf   = ($urandom_range(7) == 0);
            s_stb  = ($urandom_range(2) == 0);
            s_reti = ($urandom_range(9) == 0);
            s_ret  = ($urandom_range(9) == 0);
            s_set  = ($urandom_range(19) == 0);
            s_clr  = ($urandom_range(19) == 0);
            tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule